// File: doc/BRIEF.md
# Chained Double-Shift Funnel Unit

This block shifts a 64-bit word left or right by an amount from 0 to 63. The positions left empty by the shift are filled from a second word. The bits pushed out of the first word come back on a separate spill output, and a flag shows whether any of those bits were nonzero. Because of this, a wide integer held as a run of 64-bit words can be shifted one word at a time. The spill from one step feeds the fill input of the next.

The shift amount comes from the low six bits of a full source word. Every output is registered in a single stage, so results appear one clock after the operands are presented. A four-bit condition field describes the result as a signed number and also copies the overflow flag. This field changes only on cycles where the record input is high, and otherwise keeps its last value.

Top module: `dshift_funnel`

## Requirements
- R1: While `rst_n` is low, `result`, `spill`, `ovf` and `cond` are all zero.
- R2: The shift amount n is `amt[5:0]`. Bits `amt[63:6]` have no effect on any output.
- R3: When `dir_right` is 0 (left), `result` equals `a` shifted left by n, with `result[n-1:0]` taken from `c[n-1:0]`.
- R4: When `dir_right` is 0, `spill[n-1:0]` holds `a[63:64-n]` and the other bits of `spill` are zero.
- R5: When `dir_right` is 1 (right), `result` equals `a` shifted right by n, with `result[63:64-n]` taken from `c[63:64-n]`.
- R6: When `dir_right` is 1, `spill[63:64-n]` holds `a[n-1:0]` and the other bits of `spill` are zero.
- R7: `ovf` is 1 exactly when `spill` is nonzero.
- R8: When n = 0, in either direction, `result` equals `a`, `spill` is zero and `ovf` is 0.
- R9: `cond` is loaded only on a clock edge where `rec_en` is 1. On every other edge it keeps its value.
- R10: When `cond` is loaded, the bits mean: bit 3 = result negative (bit 63 set), bit 2 = result positive and nonzero, bit 1 = result zero, bit 0 = the new `ovf`.
- R11: All outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | 64 | Word to be shifted |
| c | input | 64 | Fill word for the vacated positions |
| amt | input | 64 | Shift source word; only the low 6 bits are used |
| dir_right | input | 1 | 0 selects a left shift, 1 selects a right shift |
| rec_en | input | 1 | Allows `cond` to be loaded on this edge |
| result | output | 64 | Shifted word merged with the fill bits |
| spill | output | 64 | Bits shifted out of `a` |
| ovf | output | 1 | High when `spill` is nonzero |
| cond | output | 4 | {negative, positive, zero, overflow summary} |

## Verification
A wrong mask boundary would show up one cycle later as a single wrong bit at the edge between shifted and filled bits. The shifts by 1 and by 63 expose this directly. A flaw in the rotate would corrupt the result and the spill at the same time, in a way that a 128-bit concatenate-and-shift model catches. A condition register that loads when it should hold only shows up on the cycle after `rec_en` goes low. The bench therefore runs sequences in which the result changes sign while `rec_en` stays low.

// File: rtl/dshift_funnel.sv
module dshift_funnel #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] c,
  input  logic [W-1:0] amt,
  input  logic         dir_right,
  input  logic         rec_en,
  output logic [W-1:0] result,
  output logic [W-1:0] spill,
  output logic         ovf,
  output logic [3:0]   cond
);
  localparam int SW = $clog2(W);

  logic [SW-1:0]  n;
  logic [SW:0]    rot_amt;
  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot, ones, keep_mask, fill_mask, res_d, spill_d;

  assign n       = amt[SW-1:0];
  assign ones    = '1;
  assign rot_amt = dir_right ? (SW+1)'(W) - {1'b0, n} : {1'b0, n};
  assign dbl     = {a, a} << rot_amt;
  assign rot     = dbl[2*W-1:W];

  assign fill_mask = dir_right ? ~(ones >> n) : ~(ones << n);
  assign keep_mask = ~fill_mask;

  assign res_d   = (rot & keep_mask) | (c & fill_mask);
  assign spill_d = rot & fill_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      spill  <= '0;
      ovf    <= 1'b0;
      cond   <= '0;
    end else begin
      result <= res_d;
      spill  <= spill_d;
      ovf    <= |spill_d;
      if (rec_en)
        cond <= {res_d[W-1], ~res_d[W-1] & (|res_d), ~(|res_d), |spill_d};
    end
  end
endmodule

module dshift_funnel_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] amt,
  input logic         rec_en,
  input logic [W-1:0] result,
  input logic [W-1:0] spill,
  input logic         ovf,
  input logic [3:0]   cond
);
  AST_OVF_SET:   assert property (@(posedge clk) disable iff (!rst_n) ovf |-> spill != '0); // R7
  AST_OVF_CLR:   assert property (@(posedge clk) disable iff (!rst_n) !ovf |-> spill == '0); // R7
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) (amt[5:0] == 6'd0) |=> (spill == '0 && !ovf)); // R8
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rec_en |=> $stable(cond)); // R9
  AST_COND_SIGN: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cond[3:1])); // R10
  AST_COND_OVF:  assert property (@(posedge clk) disable iff (!rst_n) rec_en |=> cond[0] == ovf); // R10
  AST_COND_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rec_en |=> cond[1] == (result == '0)); // R10
endmodule

bind dshift_funnel dshift_funnel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .amt(amt), .rec_en(rec_en),
  .result(result), .spill(spill), .ovf(ovf), .cond(cond)
);

// File: tb/tb_dshift_funnel.sv
module tb_dshift_funnel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] a = '0, c = '0, amt = '0;
  logic dir_right = 1'b0, rec_en = 1'b0;
  logic [63:0] result, spill;
  logic ovf;
  logic [3:0] cond;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic [63:0] sp;
    logic        ov;
    logic [3:0]  cd;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [3:0] cond_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dshift_funnel dut (
    .clk(clk), .rst_n(rst_n), .a(a), .c(c), .amt(amt),
    .dir_right(dir_right), .rec_en(rec_en),
    .result(result), .spill(spill), .ovf(ovf), .cond(cond)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: 128-bit concatenation shifted, then fill from c
  task automatic drive(input logic [63:0] ia, input logic [63:0] ic, input logic [63:0] iamt,
                       input logic idir, input logic irec, input string tag);
    exp_t e;
    logic [127:0] w;
    logic [63:0] fm;
    int n;
    n = int'(iamt[5:0]);
    if (!idir) begin
      w = {64'd0, ia} << n;
      fm = (n == 0) ? 64'd0 : ({64{1'b1}} >> (64 - n));
      e.res = w[63:0] | (ic & fm);
      e.sp  = w[127:64];
    end else begin
      w = {ia, 64'd0} >> n;
      fm = (n == 0) ? 64'd0 : ({64{1'b1}} << (64 - n));
      e.res = w[127:64] | (ic & fm);
      e.sp  = w[63:0];
    end
    e.ov = (e.sp != 0);
    if (irec)
      cond_model = {e.res[63], !e.res[63] && e.res != 0, e.res == 0, e.ov};
    e.cd = cond_model;
    e.tag = tag;
    @(negedge clk);
    a = ia; c = ic; amt = iamt; dir_right = idir; rec_en = irec;
    q.push_back(e);
  endtask

  // Monitor: results appear one edge after the operands (R11)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " result R11"}, result, e.res);
        chk({e.tag, " spill R4/R6"}, spill, e.sp);
        chk({e.tag, " ovf R7"}, {63'd0, ovf}, {63'd0, e.ov});
        chk({e.tag, " cond R9/R10"}, {60'd0, cond}, {60'd0, e.cd});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = 64'hFFFF_0000_1234_5678; c = 64'hFFFF_FFFF_FFFF_FFFF;
    amt = 64'd5; rec_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 result", result, 64'd0);
    chk("R1 spill", spill, 64'd0);
    chk("R1 ovf", {63'd0, ovf}, 64'd0);
    chk("R1 cond", {60'd0, cond}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1; rec_en = 1'b0;

    drive(64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b1, "R8 left n0");
    drive(64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1'b1, "R8 right n0");
    drive(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'd1, 1'b0, 1'b1, "R3 left n1");
    drive(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'd1, 1'b1, 1'b1, "R5 right n1");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'd63, 1'b0, 1'b1, "R3 left n63");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'd63, 1'b1, 1'b1, "R5 right n63");
    drive(64'h0000_0000_0000_00F0, 64'h0, 64'd4, 1'b0, 1'b1, "R7 left no spill");
    drive(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_FFFF_FFC8, 1'b0, 1'b1, "R2 upper amt left");
    drive(64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 64'hA5A5_0000_0000_0048, 1'b1, 1'b1, "R2 upper amt right");
    drive(64'h0, 64'h0, 64'd10, 1'b0, 1'b1, "R10 zero result");
    // cond must hold across sign and overflow changes with record off
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd8, 1'b0, 1'b0, "R9 hold neg");
    drive(64'h0000_0000_0000_0001, 64'h0, 64'd2, 1'b1, 1'b0, "R9 hold ovf");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'd0, 1'b0, 1'b1, "R10 positive");
    drive(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, 1'b1, "R10 negative fill");

    for (int i = 0; i < 300; i++) begin
      logic dr;
      dr = 1'($urandom);
      drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            dr, 1'($urandom), dr ? "R5/R6 random" : "R3/R4 random");
    end

    repeat (4) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule